// File: doc/BRIEF.md
# Latched Interrupt Status and Enable Unit

This unit sits beside a serial-peripheral controller and turns its event lines into one interrupt request. Each of seven event inputs is watched for a low-to-high transition; a transition sets a sticky bit in a status register. A per-source enable register selects which sticky bits may raise the request. A single global enable, kept apart from the per-source enables, gates the request as a whole. The request output is registered.

Software services the unit through a small word-wide register port. It reads the status register and writes the same word back: every bit written as one is cleared, every bit written as zero is left alone. An event that rises in the very cycle of such a write keeps its bit set, so no event is lost between the read and the write-back. Writing zero to both enable registers silences the request no matter what is pending.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status, per-source enable and global enable registers read as zero and `irq_o` is low.
- R2: A status bit is set only by a rising edge on its event input; an event held high after its bit was cleared does not set it again.
- R3: Event input bit i sets status bit i. The source assignment is: bit 0 mode fault, bit 1 selected-while-disabled fault, bit 2 transmit queue drained (last word shifted out), bit 3 transmit underrun, bit 4 receive queue full, bit 5 receive overrun, bit 6 transmit queue half empty.
- R4: A write to the status register (address 0) clears exactly the status bits written as one and leaves the others unchanged.
- R5: When an event rises in the same cycle as a write that clears its bit, the bit stays set.
- R6: The per-source enable register (address 1, bits 6:0, bit i for source i) masks status bit i from the request when clear.
- R7: The global enable is bit 31 of its own register (address 2); while it is clear `irq_o` stays low whatever status and enables hold.
- R8: `irq_o` equals global enable AND the OR over i of (status bit i AND enable bit i), registered: it reflects register contents one clock after they change.
- R9: Writing a status bit position that holds zero never sets it; only events set status bits.
- R10: Read data: status and enable appear in bits 6:0 with all other bits zero; the global register returns only bit 31; address 3 reads zero and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | Event lines from the controller, edge-detected |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register address (0 status, 1 enable, 2 global, 3 unused) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench sweeps all 128 pending-status patterns against a set of enable masks with the global enable off and on, so a wrong bit map, a missing mask or an inverted global gate shows up as a wrong request level. The write-back clear is checked to leave status empty, while writing ones into clear positions must not set them; a design that treats the write as a load would instead set them. An event rising in the same cycle as its clear must survive, which a design giving the clear priority would lose, and a level held high must not re-arm a cleared bit, which a level-sensitive latch would. The one-cycle request latency is sampled directly, catching a combinational or doubly registered output.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int BUS_W     = 32;
    localparam int SRC_COUNT = 7;
    localparam int ADDR_W    = 2;

    // Source positions; the controller and software decode these bits.
    localparam int SRC_MODE_FAULT    = 0;
    localparam int SRC_SEL_FAULT     = 1;
    localparam int SRC_TX_DRAINED    = 2;
    localparam int SRC_TX_UNDERRUN   = 3;
    localparam int SRC_RX_FULL       = 4;
    localparam int SRC_RX_OVERRUN    = 5;
    localparam int SRC_TX_HALF       = 6;

    typedef enum logic [ADDR_W-1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_GLOBAL = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             wr;
        reg_sel_e         sel;
        logic [BUS_W-1:0] data;
    } bus_cmd_t;

    function automatic logic [BUS_W-1:0] widen_low(input logic [SRC_COUNT-1:0] v);
        logic [BUS_W-1:0] r;
        r = '0;
        r[SRC_COUNT-1:0] = v;
        return r;
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] level_i,
    output logic [NUM_SRC-1:0] rise_o
);
    logic [NUM_SRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;

    a_r2_rise_needs_low_before: assert property (@(posedge clk) disable iff (rst)
        |rise_o |=> 1'b1 ##0 ((rise_o & $past(level_i)) == '0));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] status_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic bit_q;

        always_ff @(posedge clk) begin
            if (rst)         bit_q <= 1'b0;
            else if (rise_i[i]) bit_q <= 1'b1;
            else if (clr_i[i])  bit_q <= 1'b0;
        end

        assign status_o[i] = bit_q;

        a_r3_rise_sets_bit: assert property (@(posedge clk) disable iff (rst)
            rise_i[i] |=> status_o[i]);
        a_r4_clear_drops_bit: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !rise_i[i]) |=> !status_o[i]);
        a_r9_no_set_without_event: assert property (@(posedge clk) disable iff (rst)
            (!status_o[i] && !rise_i[i]) |=> !status_o[i]);
    end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_status_pkg::*;
#(
    parameter int NUM_SRC = SRC_COUNT,
    parameter int GIE_BIT = BUS_W - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_cmd_t           cmd_i,
    input  logic [NUM_SRC-1:0] status_i,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [NUM_SRC-1:0] en_o,
    output logic               gie_o,
    output logic [BUS_W-1:0]   rdata_o
);
    localparam logic [BUS_W-1:0] SRC_MASK = BUS_W'((64'd1 << NUM_SRC) - 64'd1);
    localparam logic [BUS_W-1:0] GIE_MASK = BUS_W'(64'd1 << GIE_BIT);

    logic [NUM_SRC-1:0] en_q;
    logic               gie_q;
    logic               unused_wdata;

    assign unused_wdata = ^(cmd_i.data & ~(SRC_MASK | GIE_MASK));

    assign clr_o = (cmd_i.wr && cmd_i.sel == REG_STATUS) ? cmd_i.data[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            gie_q <= 1'b0;
        end else if (cmd_i.wr) begin
            case (cmd_i.sel)
                REG_ENABLE: en_q  <= cmd_i.data[NUM_SRC-1:0];
                REG_GLOBAL: gie_q <= cmd_i.data[GIE_BIT];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        case (cmd_i.sel)
            REG_STATUS: rdata_o[NUM_SRC-1:0] = status_i;
            REG_ENABLE: rdata_o[NUM_SRC-1:0] = en_q;
            REG_GLOBAL: rdata_o[GIE_BIT]     = gie_q;
            default:    rdata_o = '0;
        endcase
    end

    assign en_o  = en_q;
    assign gie_o = gie_q;

    a_r10_none_write_keeps_enable: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.wr && cmd_i.sel == REG_NONE) |=> $stable(en_q) && $stable(gie_q));

endmodule

// File: rtl/irq_output.sv
module irq_output #(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               gie_i,
    output logic               irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= gie_i & (|(status_i & en_i));
    end

    assign irq_o = irq_q;

    a_r7_global_gate: assert property (@(posedge clk) disable iff (rst)
        !gie_i |=> !irq_o);
    a_r6_masked_silent: assert property (@(posedge clk) disable iff (rst)
        ((status_i & en_i) == '0) |=> !irq_o);
    a_r8_request_follows: assert property (@(posedge clk) disable iff (rst)
        (gie_i && (status_i & en_i) != '0) |=> irq_o);

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int NUM_SRC = SRC_COUNT,
    parameter int GIE_BIT = BUS_W - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               irq_o
);
    bus_cmd_t           cmd;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] en;
    logic               gie;

    assign cmd.wr   = bus_wr;
    assign cmd.sel  = reg_sel_e'(bus_addr);
    assign cmd.data = bus_wdata;

    irq_edge_detect #(.NUM_SRC(NUM_SRC)) u_edge (
        .clk(clk), .rst(rst), .level_i(evt_i), .rise_o(rise)
    );

    irq_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk(clk), .rst(rst), .rise_i(rise), .clr_i(clr), .status_o(status)
    );

    irq_regfile #(.NUM_SRC(NUM_SRC), .GIE_BIT(GIE_BIT)) u_regs (
        .clk(clk), .rst(rst), .cmd_i(cmd), .status_i(status),
        .clr_o(clr), .en_o(en), .gie_o(gie), .rdata_o(bus_rdata)
    );

    irq_output #(.NUM_SRC(NUM_SRC)) u_out (
        .clk(clk), .rst(rst), .status_i(status), .en_i(en),
        .gie_i(gie), .irq_o(irq_o)
    );

    a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && (evt_i & bus_wdata[NUM_SRC-1:0]) != '0
         && $past(evt_i) == '0) |=> (status != '0));

endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  evt_i = '0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_status_unit u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [6:0] p);
        @(negedge clk);
        evt_i = p;
        @(negedge clk);
        evt_i = '0;
    endtask

    initial begin
        logic [31:0] r;
        logic [6:0]  masks [10];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, r); chk("R1 status", r, 32'h0);
        rd(2'd1, r); chk("R1 enable", r, 32'h0);
        rd(2'd2, r); chk("R1 global", r, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R3/R4/R6/R7/R8: sweep all pending patterns
        for (int p = 0; p < 128; p++) begin
            masks[0] = 7'h00; masks[8] = 7'h7f; masks[9] = ~7'(p);
            for (int k = 0; k < 7; k++) masks[k+1] = 7'(1 << k);
            pulse(7'(p));
            rd(2'd0, r); chk("R3 status map", r, 32'(p));
            for (int m = 0; m < 10; m++) begin
                wr(2'd1, {25'h0, masks[m]});
                for (int g = 0; g < 2; g++) begin
                    wr(2'd2, {g[0], 31'h0});
                    @(negedge clk);
                    chk(g == 0 ? "R7 global gate" : "R6 per-source mask",
                        {31'h0, irq_o}, {31'h0, (g == 1) && ((7'(p) & masks[m]) != 0)});
                end
            end
            wr(2'd2, 32'h0);
            wr(2'd1, 32'h0);
            wr(2'd0, 32'(p));
            rd(2'd0, r); chk("R4 write-back clears", r, 32'h0);
        end

        // R4: partial clear
        pulse(7'h55);
        wr(2'd0, 32'h05);
        rd(2'd0, r); chk("R4 partial clear", r, 32'h50);
        wr(2'd0, 32'h50);

        // R9: writing ones to empty positions sets nothing
        wr(2'd0, 32'hffff_ffff);
        rd(2'd0, r); chk("R9 no set by write", r, 32'h0);

        // R8: one-cycle latency of the request
        pulse(7'h04);
        wr(2'd1, 32'h04);
        wr(2'd2, 32'h8000_0000);
        chk("R8 not yet raised", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R8 raised one cycle later", {31'h0, irq_o}, 32'h1);
        wr(2'd0, 32'h04);
        chk("R8 still high on clear edge", {31'h0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R8 dropped after clear", {31'h0, irq_o}, 32'h0);

        // R5: event rising in the cycle of its clear survives
        pulse(7'h08);
        @(negedge clk);
        evt_i = 7'h08; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h08;
        @(negedge clk);
        evt_i = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd(2'd0, r); chk("R5 event beats clear", r, 32'h08);
        wr(2'd0, 32'h08);

        // R2: held level does not re-set after clear
        @(negedge clk);
        evt_i = 7'h20;
        @(negedge clk);
        rd(2'd0, r); chk("R2 edge sets", r, 32'h20);
        wr(2'd0, 32'h20);
        repeat (3) @(negedge clk);
        rd(2'd0, r); chk("R2 held level ignored", r, 32'h0);
        evt_i = '0;
        @(negedge clk);

        // R10: read layout and unused address
        wr(2'd1, 32'hffff_ffff);
        rd(2'd1, r); chk("R10 enable readback", r, 32'h7f);
        wr(2'd2, 32'h7fff_ffff);
        rd(2'd2, r); chk("R10 global only bit31", r, 32'h0);
        wr(2'd2, 32'hffff_ffff);
        rd(2'd2, r); chk("R10 global readback", r, 32'h8000_0000);
        wr(2'd3, 32'h0);
        rd(2'd1, r); chk("R10 unused addr keeps enable", r, 32'h7f);
        rd(2'd2, r); chk("R10 unused addr keeps global", r, 32'h8000_0000);
        rd(2'd3, r); chk("R10 unused addr reads zero", r, 32'h0);

        // R7: both enables zero silence a pending source
        pulse(7'h01);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0);
        @(negedge clk);
        chk("R7 silenced", {31'h0, irq_o}, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule